// File: doc/BRIEF.md
# Flash Operation Status Responder

This block sits on the device side of a parallel flash memory and answers host reads while an internal program or erase operation is running. A program or erase request starts an internal sequencer that stays busy for a fixed number of clock cycles, set separately for each kind of operation. The sequencer also keeps the last loaded data byte. While the sequencer is busy, a host read does not return array contents. It returns a status byte instead. The top bit is a polling bit and the next bit is a toggle bit that changes on every read. Once the operation has finished, reads return the array data, which arrives on an input port.

A separate active-low ready/busy indication is shown as an output-enable and a drive value, so that the line can be wired-OR with other devices. The line is pulled low for the whole operation and released when it ends. The array itself and the command decoder are not part of the block. A read is an interval in which chip-enable and output-enable are both low. The block captures the byte to return on the first clock edge of that interval and holds it until the next read.

Top module: `flash_status_resp`

## Requirements
- R1: After reset the block is not busy, `rb_oe` is 0, and the toggle bit is 0, so the first status read after reset shows 0 on bit DW-2.
- R2: While a program operation runs, a read returns the inverse of bit DW-1 of the loaded byte on bit DW-1 and the loaded byte's bits DW-3..0 on bits DW-3..0.
- R3: While an erase operation runs, a read returns 0 on bit DW-1 and all ones on bits DW-3..0.
- R4: Each read whose capture edge falls while busy inverts the toggle bit, and bit DW-2 of that read shows the level before inversion. The level carries over from one operation to the next and is never reset by a new operation.
- R5: A read whose capture edge falls while not busy returns `array_data` as sampled on that edge on all bits, and leaves the toggle bit unchanged.
- R6: An accepted request (`op_kind` 0 = program, 1 = erase) makes the block busy from the edge that samples `op_start` for exactly PROG_CYCLES or ERASE_CYCLES clock cycles.
- R7: `rb_oe` is 1 exactly while busy, and `rb_drv` is always 0.
- R8: A request made while busy is ignored: the running operation keeps its kind, its loaded byte and its end time.
- R9: Read data is captured once, on the first edge of a read interval. It stays stable for the rest of that interval and after it ends, however long the interval lasts, and one interval counts as one toggle.
- R10: Status is returned from the very first read whose capture edge follows the edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle request to begin an operation |
| op_kind | input | 1 | 0 = program, 1 = erase |
| ld_data | input | DW | Byte loaded by a program request |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | DW | Array contents for the addressed location |
| rd_data | output | DW | Captured read data or status byte |
| rb_oe | output | 1 | Enable of the open-drain ready/busy driver (1 = pull low) |
| rb_drv | output | 1 | Value driven when enabled, always 0 |

## Verification
The assertions assume that `op_start` is 0 whenever `rst_n` is released. They also assume that every read interval is separated from the next by at least one clock cycle in which chip-enable or output-enable is high, so that each interval produces one capture edge. The stimulus only changes inputs on falling clock edges. It always releases both enables for at least one full cycle between reads, and it pulses `op_start` for one cycle at a time. Some of those pulses are deliberately issued during a running operation.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  // Status byte returned while an operation runs: polling bit on top,
  // toggle bit below it, low field from loaded data or all ones.
  function automatic logic [7:0] status_word8(op_kind_e kind, logic [7:0] held, logic tog);
    logic [7:0] w;
    if (kind == OP_PROG) w = {~held[7], tog, held[5:0]};
    else                 w = {1'b0, tog, 6'h3F};
    return w;
  endfunction

  // Cycles to load into the down counter so busy lasts exactly len cycles.
  function automatic int unsigned load_count(int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

endpackage

// File: rtl/fsr_read_strobe.sv
module fsr_read_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic rd_act,
  output logic rd_strb
);
  logic act_q;

  assign rd_act  = ~ce_n & ~oe_n;
  assign rd_strb = rd_act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= rd_act;
  end
endmodule

// File: rtl/fsr_op_seq.sv
module fsr_op_seq
  import flash_status_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  op_kind_e      op_kind,
  input  logic [DW-1:0] ld_data,
  output logic          busy,
  output op_kind_e      kind_q,
  output logic [DW-1:0] data_q,
  output logic          cnt_zero,
  output logic          accept
);
  localparam int unsigned MAXLEN = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW     = (MAXLEN < 2) ? 1 : $clog2(MAXLEN);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(load_count(PROG_CYCLES));
  localparam logic [CW-1:0] ERASE_LOAD = CW'(load_count(ERASE_CYCLES));

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_init;

  assign accept   = op_start & ~busy;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_init = (op_kind == OP_PROG) ? PROG_LOAD : ERASE_LOAD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PROG;
      data_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt_q  <= cnt_init;
      kind_q <= op_kind;
      if (op_kind == OP_PROG) data_q <= ld_data;
    end else if (busy) begin
      if (cnt_zero) busy <= 1'b0;
      else          cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic tog_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog_q <= 1'b0;
    else if (flip) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/fsr_rd_mux.sv
module fsr_rd_mux
  import flash_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb,
  input  logic          busy,
  input  op_kind_e      kind,
  input  logic [DW-1:0] held,
  input  logic          tog,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_q
);
  localparam int unsigned LW = DW - 2;

  logic [DW-1:0] status_w;

  generate
    if (DW == 8) begin : g_byte
      assign status_w = status_word8(kind, held, tog);
    end else begin : g_wide
      logic [LW-1:0] low_f;
      assign low_f    = (kind == OP_PROG) ? held[LW-1:0] : {LW{1'b1}};
      assign status_w = {(kind == OP_PROG) ? ~held[DW-1] : 1'b0, tog, low_f};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_q <= '0;
    else if (strb) rd_q <= busy ? status_w : array_data;
  end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_status_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic          op_kind,
  input  logic [DW-1:0] ld_data,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rb_oe,
  output logic          rb_drv
);
  // Named internal events, visible to the bound checker.
  logic          rd_act;
  logic          rd_strb;
  logic          busy;
  logic          cnt_zero;
  logic          accept;
  logic          tog_flip;
  logic          tog_q;
  op_kind_e      kind_q;
  logic [DW-1:0] data_q;

  fsr_read_strobe u_strb (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .rd_act  (rd_act),
    .rd_strb (rd_strb)
  );

  fsr_op_seq #(
    .DW           (DW),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_kind  (op_kind_e'(op_kind)),
    .ld_data  (ld_data),
    .busy     (busy),
    .kind_q   (kind_q),
    .data_q   (data_q),
    .cnt_zero (cnt_zero),
    .accept   (accept)
  );

  assign tog_flip = rd_strb & busy;

  fsr_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .flip  (tog_flip),
    .tog_q (tog_q)
  );

  fsr_rd_mux #(.DW(DW)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (rd_strb),
    .busy       (busy),
    .kind       (kind_q),
    .held       (data_q),
    .tog        (tog_q),
    .array_data (array_data),
    .rd_q       (rd_data)
  );

  assign rb_oe  = busy;
  assign rb_drv = 1'b0;
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic          busy,
  input logic          rd_strb,
  input logic          tog_q,
  input logic          kind_q,
  input logic [DW-1:0] data_q,
  input logic          cnt_zero,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] array_data,
  input logic          rb_oe
);
  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb && busy && !kind_q) |=> (rd_data[DW-1] == ~$past(data_q[DW-1])));
  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb && busy && kind_q) |=> (!rd_data[DW-1] && (&rd_data[DW-3:0])));
  // R4
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb && busy) |=> (tog_q != $past(tog_q)));
  // R5
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strb && busy) |=> $stable(tog_q));
  // R5
  array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb && !busy) |=> (rd_data == $past(array_data)));
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_zero) |=> !busy);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_oe) |-> $past(op_start));
  // R8
  ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_start) |=> ($stable(kind_q) && $stable(data_q)));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strb |=> $stable(rd_data));
endmodule

bind flash_status_resp fsr_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_start   (op_start),
  .busy       (busy),
  .rd_strb    (rd_strb),
  .tog_q      (tog_q),
  .kind_q     (kind_q),
  .data_q     (data_q),
  .cnt_zero   (cnt_zero),
  .rd_data    (rd_data),
  .array_data (array_data),
  .rb_oe      (rb_oe)
);

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;
  localparam int DW = 8;
  localparam int PL = 40;
  localparam int EL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0;
  logic          op_kind = 1'b0;
  logic [DW-1:0] ld_data = '0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;
  logic          rb_oe;
  logic          rb_drv;

  always #4 clk = ~clk;

  flash_status_resp #(.DW(DW), .PROG_CYCLES(PL), .ERASE_CYCLES(EL)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .ld_data(ld_data), .ce_n(ce_n), .oe_n(oe_n), .array_data(array_data),
    .rd_data(rd_data), .rb_oe(rb_oe), .rb_drv(rb_drv)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  int        e0 = -1000;
  int        m_len = 0;
  bit        m_erase = 0;
  bit [7:0]  m_data = 0;
  bit        m_tog = 0;

  typedef struct { logic [DW-1:0] exp; string req; } item_t;
  item_t sb_q[$];
  event  smp_ev;

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_busy(int e);
    return (e > e0) && (e <= e0 + m_len);
  endfunction

  // Monitor: pops expected items and compares read data
  initial forever begin
    @(smp_ev);
    if (sb_q.size() == 0) check(0, "SB-empty", rd_data, '0);
    else begin
      item_t it;
      it = sb_q.pop_front();
      check(rd_data === it.exp, it.req, rd_data, it.exp);
    end
  end

  // Request an operation; inputs set on a falling edge
  task automatic request(bit erase, logic [7:0] d);
    int e;
    e = cyc + 1;
    op_start = 1'b1; op_kind = erase; ld_data = d;
    if (!m_busy(e)) begin
      e0 = e; m_erase = erase; m_len = erase ? EL : PL;
      if (!erase) m_data = d;
    end
    @(negedge clk);
    op_start = 1'b0;
  endtask

  // Driver: one read interval of 'hold' cycles, expected value queued
  task automatic do_read(logic [7:0] arr, int hold, string req);
    int e;
    item_t it;
    logic [DW-1:0] cap;
    e = cyc + 1;
    ce_n = 1'b0; oe_n = 1'b0; array_data = arr;
    if (m_busy(e)) begin
      it.exp = m_erase ? {1'b0, m_tog, 6'h3F} : {~m_data[7], m_tog, m_data[5:0]};
      m_tog = ~m_tog;
    end else it.exp = arr;
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    ->smp_ev;
    #1;
    cap = rd_data;
    for (int i = 1; i < hold; i++) begin
      array_data = ~arr;
      @(negedge clk);
      check(rd_data === cap, "R9 hold", rd_data, cap);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    check(rd_data === cap, "R9 after", rd_data, cap);
  endtask

  task automatic wait_idle();
    while (cyc <= e0 + m_len) @(negedge clk);
  endtask

  // Counts busy cycles seen on rb_oe after a request
  task automatic measure(bit erase, logic [7:0] d, string req);
    int n;
    n = 0;
    request(erase, d);
    while (rb_oe === 1'b1 && n < 1000) begin
      n++;
      check(rb_drv === 1'b0, "R7 drv", rb_drv, 1'b0);
      @(negedge clk);
    end
    check(n == (erase ? EL : PL), req, n[DW-1:0], erase ? EL[DW-1:0] : PL[DW-1:0]);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rb_oe === 1'b0, "R1 rb_oe", rb_oe, 1'b0);
    check(rb_drv === 1'b0, "R7 drv reset", rb_drv, 1'b0);
    do_read(8'h5A, 1, "R5 idle read");
    do_read(8'hC3, 3, "R5 idle read 2");

    // R6/R7 durations
    measure(1'b0, 8'h3C, "R6 program length");
    measure(1'b1, 8'h00, "R6 erase length");

    // Program 0xA5: first status read shows toggle 0 (R1, R10)
    request(1'b0, 8'hA5);
    do_read(8'h11, 1, "R10 R1 R2 first status");
    do_read(8'h22, 1, "R2 R4 second");
    request(1'b1, 8'h00);               // ignored, R8
    do_read(8'h33, 2, "R8 R2 after ignored");
    do_read(8'h44, 1, "R4 R2 fourth");
    wait_idle();
    check(rb_oe === 1'b0, "R8 R6 end time", rb_oe, 1'b0);
    do_read(8'h96, 1, "R5 after program");
    do_read(8'h69, 1, "R5 no toggle");

    // Erase: toggle level carries over (R4), long read counts once (R9)
    request(1'b1, 8'hFF);
    do_read(8'h01, 1, "R3 R10 erase first");
    do_read(8'h02, 5, "R3 R9 long read");
    do_read(8'h03, 1, "R3 R4 after long");
    request(1'b0, 8'h12);               // ignored, R8
    do_read(8'h04, 1, "R8 R3 kind kept");
    wait_idle();
    do_read(8'hE7, 1, "R5 after erase");

    // Program with top bit clear
    request(1'b0, 8'h7E);
    do_read(8'h00, 1, "R2 top bit clear");
    do_read(8'h00, 2, "R2 R4 next");
    wait_idle();
    do_read(8'hFF, 1, "R5 final");

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "SB drained", '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule